// File: doc/BRIEF.md
# Display Controller Suspend Sequencer

This block sits between the host bus, the panel pads and the frame-memory refresh logic of an LCD display controller, and handles entry to and exit from hardware suspend. An asynchronous active-low suspend request is synchronised into the core clock. While it is active, the block masks the host address, data and control inputs towards the core and forces the panel data nibbles and panel timing lines to a safe state. A select input picks either high impedance (output enable dropped) or a driven low level. The active-low panel power enable is also driven high.

When suspend is released, the panel stays forced and unpowered until a programmable number of frame periods has passed. The same hold applies after reset. While the block is suspended or software has programmed the deepest power-save mode, it generates CAS-before-RAS refresh strobes from a slow refresh clock. That clock is picked from three inputs: the pixel clock, the memory-enable input or a dedicated power-down clock. Each rising edge of the chosen clock starts CAS, RAS follows a fixed number of core clocks later, and both end on the falling edge. The RAS low time therefore follows the high phase of the refresh clock.

Top module: `dsp_suspend_seq`

## Requirements
- R1: Two core clock edges after `suspend_ni` goes low, the panel outputs are forced and the bus outputs are masked, whatever value `sw_mode_i` has. After only one edge the outputs still follow their inputs.
- R2: While the synchronised suspend is active, `bus_addr_o`, `bus_data_o` and `bus_ctl_o` are all zero. Otherwise each equals the matching input.
- R3: While the panel is forced, `pnl_ud_o`, `pnl_ld_o` and `pnl_ctl_o` are zero, and `pnl_oe_o` is 0 when `hiz_sel_i`=1 (high impedance) and 1 when `hiz_sel_i`=0 (driven low). While the panel is not forced, the outputs follow their inputs and `pnl_oe_o`=1.
- R4: `pnl_pwr_no` is 1 while the panel is forced and 0 otherwise.
- R5: After reset, and after the synchronised suspend goes inactive, the panel stays forced until `resume_frames_i` pulses of `frame_tick_i` have been counted. It is released on the next core clock edge. Ticks that arrive during suspend are not counted. With `resume_frames_i`=0, the release happens on the first edge.
- R6: Refresh strobes run only while suspend is active or `sw_mode_i`=4. Otherwise `ras_no` and `cas_no` stay 1. Suspend enables refresh for any value of `sw_mode_i`.
- R7: `ref_src_i` selects the refresh clock: 00 the pixel clock, 01 `mem_en_i`, 10 `pd_clk_i`, and 11 the pixel clock. Edges on the sources that are not selected have no effect.
- R8: `cas_no` goes low 3 core edges after a rising edge of the selected source and `ras_no` is still high at that point. `ras_no` goes low `RAS_DLY` (default 4) edges after `cas_no`. Both return high 3 edges after the source falls.
- R9: If the source falls before RAS has been asserted, `cas_no` returns high and `ras_no` never goes low in that refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| suspend_ni | input | 1 | Asynchronous hardware suspend request, active low |
| sw_mode_i | input | 3 | Software power-save mode; 4 is the deepest |
| hiz_sel_i | input | 1 | Forced panel state: 1 high impedance, 0 drive low |
| ref_src_i | input | 2 | Refresh clock source select |
| resume_frames_i | input | FW | Frame periods to wait before re-enabling the panel |
| frame_tick_i | input | 1 | One-cycle pulse per frame period |
| bus_addr_i | input | AW | Host address from the pads |
| bus_data_i | input | DW | Host data from the pads |
| bus_ctl_i | input | CW | Host control strobes from the pads |
| bus_addr_o | output | AW | Masked host address to the core |
| bus_data_o | output | DW | Masked host data to the core |
| bus_ctl_o | output | CW | Masked host control strobes to the core |
| pnl_ud_i | input | NIB | Upper panel data nibble from the pipeline |
| pnl_ld_i | input | NIB | Lower panel data nibble from the pipeline |
| pnl_ctl_i | input | 5 | Panel shift clocks, line pulse, frame start and AC modulation |
| pnl_ud_o | output | NIB | Upper panel data nibble to the pads |
| pnl_ld_o | output | NIB | Lower panel data nibble to the pads |
| pnl_ctl_o | output | 5 | Panel timing lines to the pads |
| pnl_oe_o | output | 1 | Output enable for the panel pads |
| pnl_pwr_no | output | 1 | Panel power enable, active low |
| pix_clk_i | input | 1 | Pixel clock as a refresh source |
| mem_en_i | input | 1 | Memory-enable input as a refresh source |
| pd_clk_i | input | 1 | Slow power-down clock as a refresh source |
| ras_no | output | 1 | Refresh row strobe, active low |
| cas_no | output | 1 | Refresh column strobe, active low |

## Verification
The hardest case to reach is a refresh cycle cut short: the selected source must fall inside the window after CAS has asserted but before the RAS delay has run out. The stimulus measures edge by edge when `cas_no` drops and removes the source on the next half cycle. A second hard case is the resume hold, where panel release depends on frame ticks counted only after the synchronised suspend clears. The bench therefore places ticks both inside and outside suspend and samples the panel on the edge just before the release and on the edge of the release.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    REF_PIX = 2'b00,
    REF_MEM = 2'b01,
    REF_PDC = 2'b10,
    REF_RSV = 2'b11
  } ref_src_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAS,
    ST_BOTH
  } cbr_st_e;

  localparam logic [2:0] DEEP_MODE = 3'd4;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dss_power_ctrl.sv
module dss_power_ctrl #(
  parameter int unsigned FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          susp_i,
  input  logic          frame_tick_i,
  input  logic [FW-1:0] frames_i,
  output logic          panel_off_o
);
  logic          forced_q;
  logic [FW-1:0] cnt_q;

  // cnt_q never exceeds frames_i, so no wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      forced_q <= 1'b1;
      cnt_q    <= '0;
    end else if (susp_i) begin
      forced_q <= 1'b1;
      cnt_q    <= '0;
    end else if (forced_q) begin
      if (cnt_q >= frames_i) forced_q <= 1'b0;
      else if (frame_tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign panel_off_o = susp_i | forced_q;

  assert_hold_in_susp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_i |=> forced_q);

  assert_release_after_frames_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(forced_q) |-> $past(cnt_q >= frames_i));
endmodule

// File: rtl/dss_refresh.sv
module dss_refresh
  import dss_pkg::*;
#(
  parameter int unsigned RAS_DLY = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lp_active_i,
  input  ref_src_e src_i,
  input  logic     pix_clk_i,
  input  logic     mem_en_i,
  input  logic     pd_clk_i,
  output logic     ras_no,
  output logic     cas_no
);
  localparam int unsigned CNTW = $clog2(RAS_DLY + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(RAS_DLY - 1);

  logic [2:0]      src_sync;
  logic            sel, prev_q, rise, fall;
  cbr_st_e         st_q;
  logic [CNTW-1:0] cnt_q;
  logic            ras_q, cas_q;

  dss_sync #(.W(3), .RST_VAL(3'b000)) u_src_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pd_clk_i, mem_en_i, pix_clk_i}),
    .q_o   (src_sync)
  );

  always_comb begin
    unique case (src_i)
      REF_MEM: sel = src_sync[1];
      REF_PDC: sel = src_sync[2];
      REF_PIX,
      REF_RSV: sel = src_sync[0];
    endcase
  end

  assign rise = sel & ~prev_q;
  assign fall = ~sel & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
    end else begin
      prev_q <= sel;
      if (!lp_active_i) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
        ras_q <= 1'b1;
        cas_q <= 1'b1;
      end else begin
        unique case (st_q)
          ST_IDLE: if (rise) begin
            st_q  <= ST_CAS;
            cas_q <= 1'b0;
            cnt_q <= '0;
          end
          ST_CAS: begin
            if (fall) begin
              st_q  <= ST_IDLE;
              cas_q <= 1'b1;
            end else if (cnt_q == LAST) begin
              st_q  <= ST_BOTH;
              ras_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BOTH: if (fall) begin
            st_q  <= ST_IDLE;
            ras_q <= 1'b1;
            cas_q <= 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ras_no = ras_q;
  assign cas_no = cas_q;

  assert_cbr_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_q |-> !cas_q);

  assert_cas_leads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_q) |-> ras_q);

  assert_idle_strobes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_active_i |=> (ras_q && cas_q));
endmodule

// File: rtl/dsp_suspend_seq.sv
module dsp_suspend_seq
  import dss_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned CW      = 4,
  parameter int unsigned NIB     = 4,
  parameter int unsigned FW      = 8,
  parameter int unsigned RAS_DLY = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          suspend_ni,
  input  logic [2:0]    sw_mode_i,
  input  logic          hiz_sel_i,
  input  logic [1:0]    ref_src_i,
  input  logic [FW-1:0] resume_frames_i,
  input  logic          frame_tick_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic [CW-1:0] bus_ctl_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_data_o,
  output logic [CW-1:0] bus_ctl_o,
  input  logic [NIB-1:0] pnl_ud_i,
  input  logic [NIB-1:0] pnl_ld_i,
  input  logic [4:0]    pnl_ctl_i,
  output logic [NIB-1:0] pnl_ud_o,
  output logic [NIB-1:0] pnl_ld_o,
  output logic [4:0]    pnl_ctl_o,
  output logic          pnl_oe_o,
  output logic          pnl_pwr_no,
  input  logic          pix_clk_i,
  input  logic          mem_en_i,
  input  logic          pd_clk_i,
  output logic          ras_no,
  output logic          cas_no
);
  logic susp_n_sync, susp, panel_off, lp_active;

  dss_sync #(.W(1), .RST_VAL(1'b1)) u_susp_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (suspend_ni),
    .q_o   (susp_n_sync)
  );
  assign susp = ~susp_n_sync;

  dss_power_ctrl #(.FW(FW)) u_pwr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .susp_i      (susp),
    .frame_tick_i(frame_tick_i),
    .frames_i    (resume_frames_i),
    .panel_off_o (panel_off)
  );

  assign lp_active = susp | (sw_mode_i == DEEP_MODE);

  dss_refresh #(.RAS_DLY(RAS_DLY)) u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lp_active_i(lp_active),
    .src_i      (ref_src_e'(ref_src_i)),
    .pix_clk_i  (pix_clk_i),
    .mem_en_i   (mem_en_i),
    .pd_clk_i   (pd_clk_i),
    .ras_no     (ras_no),
    .cas_no     (cas_no)
  );

  assign bus_addr_o = susp ? '0 : bus_addr_i;
  assign bus_data_o = susp ? '0 : bus_data_i;
  assign bus_ctl_o  = susp ? '0 : bus_ctl_i;

  assign pnl_ud_o   = panel_off ? '0 : pnl_ud_i;
  assign pnl_ld_o   = panel_off ? '0 : pnl_ld_i;
  assign pnl_ctl_o  = panel_off ? '0 : pnl_ctl_i;
  assign pnl_oe_o   = panel_off ? ~hiz_sel_i : 1'b1;
  assign pnl_pwr_no = panel_off;

  assert_bus_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp |-> (bus_addr_o == '0 && bus_data_o == '0 && bus_ctl_o == '0));

  assert_pwr_off_in_susp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pnl_pwr_no |-> !susp);
endmodule

// File: tb/dsp_suspend_seq_tb.sv
`timescale 1ns/1ps
module dsp_suspend_seq_tb;
  localparam int RAS_DLY = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic suspend_ni = 1'b1;
  logic [2:0] sw_mode = 3'd0;
  logic hiz_sel = 1'b1;
  logic [1:0] ref_src = 2'b10;
  logic [7:0] resume_frames = 8'd0;
  logic frame_tick = 1'b0;
  logic [15:0] bus_addr = 16'hA55A, bus_data = 16'h1234;
  logic [3:0] bus_ctl = 4'hB;
  logic [15:0] bus_addr_o, bus_data_o;
  logic [3:0] bus_ctl_o;
  logic [3:0] pnl_ud = 4'h9, pnl_ld = 4'h6;
  logic [4:0] pnl_ctl = 5'h15;
  logic [3:0] pnl_ud_o, pnl_ld_o;
  logic [4:0] pnl_ctl_o;
  logic pnl_oe_o, pnl_pwr_no;
  logic pix_clk = 1'b0, mem_en = 1'b0, pd_clk = 1'b0;
  logic ras_no, cas_no;

  int vec = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsp_suspend_seq #(.RAS_DLY(RAS_DLY)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .suspend_ni(suspend_ni), .sw_mode_i(sw_mode),
    .hiz_sel_i(hiz_sel), .ref_src_i(ref_src), .resume_frames_i(resume_frames),
    .frame_tick_i(frame_tick), .bus_addr_i(bus_addr), .bus_data_i(bus_data),
    .bus_ctl_i(bus_ctl), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
    .bus_ctl_o(bus_ctl_o), .pnl_ud_i(pnl_ud), .pnl_ld_i(pnl_ld), .pnl_ctl_i(pnl_ctl),
    .pnl_ud_o(pnl_ud_o), .pnl_ld_o(pnl_ld_o), .pnl_ctl_o(pnl_ctl_o),
    .pnl_oe_o(pnl_oe_o), .pnl_pwr_no(pnl_pwr_no), .pix_clk_i(pix_clk),
    .mem_en_i(mem_en), .pd_clk_i(pd_clk), .ras_no(ras_no), .cas_no(cas_no)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic drive_src(input int which, input logic v);
    case (which)
      0: pix_clk = v;
      1: mem_en = v;
      default: pd_clk = v;
    endcase
  endtask

  function automatic logic [63:0] pnl_out();
    return {pnl_ud_o, pnl_ld_o, pnl_ctl_o, pnl_oe_o, pnl_pwr_no};
  endfunction

  task automatic t_reset();
    #1;
    check("R4 reset pwr", pnl_pwr_no, 1'b1);
    check("R5 reset panel forced", pnl_ctl_o, 5'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1);
    check("R5 release after reset (0 frames)", pnl_out(), {4'h9, 4'h6, 5'h15, 1'b1, 1'b0});
    check("R2 bus pass", {bus_addr_o, bus_data_o, bus_ctl_o}, {16'hA55A, 16'h1234, 4'hB});
  endtask

  task automatic t_suspend_entry();
    sw_mode = 3'd2;
    suspend_ni = 1'b0;
    step(1);
    check("R1 one edge bus still live", bus_addr_o, 16'hA55A);
    check("R1 one edge pwr still on", pnl_pwr_no, 1'b0);
    step(1);
    check("R1 R2 bus masked", {bus_addr_o, bus_data_o, bus_ctl_o}, 36'h0);
    check("R1 R4 pwr off", pnl_pwr_no, 1'b1);
    bus_addr = 16'hFFFF; bus_data = 16'hFFFF; bus_ctl = 4'hF;
    #1;
    check("R2 bus ignored while suspended", {bus_addr_o, bus_data_o, bus_ctl_o}, 36'h0);
  endtask

  task automatic t_hiz_select();
    hiz_sel = 1'b1;
    #1;
    check("R3 hiz forced", {pnl_ud_o, pnl_ld_o, pnl_ctl_o, pnl_oe_o}, 14'h0);
    hiz_sel = 1'b0;
    #1;
    check("R3 drive-low forced", {pnl_ud_o, pnl_ld_o, pnl_ctl_o, pnl_oe_o}, 14'h1);
    hiz_sel = 1'b1;
  endtask

  task automatic t_cbr(input int which, input string req);
    int n;
    drive_src(which, 1'b1);
    n = 0;
    do begin step(1); n++; end while (cas_no && n < 10);
    check({req, " cas delay"}, n, 3);
    check({req, " ras high at cas"}, ras_no, 1'b1);
    n = 0;
    do begin step(1); n++; end while (ras_no && n < 12);
    check({req, " ras delay"}, n, RAS_DLY);
    step(2);
    drive_src(which, 1'b0);
    n = 0;
    do begin step(1); n++; end while (!(ras_no && cas_no) && n < 10);
    check({req, " release delay"}, n, 3);
    step(2);
  endtask

  task automatic t_no_cbr(input int which, input string req);
    logic seen;
    seen = 1'b0;
    drive_src(which, 1'b1);
    for (int i = 0; i < 10; i++) begin step(1); seen |= ~cas_no | ~ras_no; end
    drive_src(which, 1'b0);
    for (int i = 0; i < 5; i++) begin step(1); seen |= ~cas_no | ~ras_no; end
    check({req, " no strobe"}, seen, 1'b0);
  endtask

  task automatic t_susp_refresh();
    sw_mode = 3'd0;
    ref_src = 2'b10;
    t_cbr(2, "R6 R8 suspend pd clock");
  endtask

  task automatic t_resume();
    resume_frames = 8'd2;
    frame_tick = 1'b1;
    step(1);
    frame_tick = 1'b0;
    suspend_ni = 1'b1;
    step(3);
    check("R5 hold after resume", pnl_pwr_no, 1'b1);
    frame_tick = 1'b1; step(1); frame_tick = 1'b0;
    step(1);
    check("R5 hold after one tick", pnl_pwr_no, 1'b1);
    frame_tick = 1'b1; step(1); frame_tick = 1'b0;
    check("R5 hold on edge of last tick", pnl_pwr_no, 1'b1);
    step(1);
    check("R5 released", pnl_out(), {4'h9, 4'h6, 5'h15, 1'b1, 1'b0});
    check("R2 bus restored", bus_addr_o, 16'hFFFF);
  endtask

  task automatic t_sources();
    sw_mode = 3'd0; ref_src = 2'b10;
    t_no_cbr(2, "R6 mode 0 awake");
    sw_mode = 3'd4;
    t_cbr(2, "R7 R8 mode4 sel10 pd");
    ref_src = 2'b01;
    t_cbr(1, "R7 sel01 mem_en");
    t_no_cbr(2, "R7 sel01 pd ignored");
    ref_src = 2'b11;
    t_cbr(0, "R7 sel11 pixel");
    ref_src = 2'b00;
    t_no_cbr(1, "R7 sel00 mem_en ignored");
  endtask

  task automatic t_short_phase();
    int n;
    logic ras_seen;
    ref_src = 2'b10; sw_mode = 3'd4;
    pd_clk = 1'b1;
    n = 0;
    do begin step(1); n++; end while (cas_no && n < 10);
    check("R9 cas asserted", cas_no, 1'b0);
    pd_clk = 1'b0;
    ras_seen = 1'b0;
    for (int i = 0; i < 8; i++) begin step(1); ras_seen |= ~ras_no; end
    check("R9 ras never low", ras_seen, 1'b0);
    check("R9 cas released", cas_no, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      vec++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_suspend_entry();
    t_hiz_select();
    t_susp_refresh();
    t_resume();
    t_sources();
    t_short_phase();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule